// File: doc/BRIEF.md
# Word-Clock Phase Tracker with Tolerance-Gated Realignment

This block produces all internal frame timing from the system clock alone, so that jitter on the incoming word clock never shows up in the frame timing it hands downstream. A frame counter counts system clocks modulo a frame length (parameter `FRAME_LEN`, default 256). The word clock first passes through a two-stage synchronizer. Its rising edge is taken as the frame start edge.

After reset is released, the counter is held at zero and the locked flag stays low until the first start edge arrives. That edge aligns the counter. Each later start edge is compared with the phase the counter expects. The counter is reloaded only when the signed phase error lies outside a tolerance chosen by a mode input. The wide tolerance is three-eighths of a frame and the narrow one is a single system clock. Each reload is flagged with a one-cycle pulse, because a jump in timing can disturb downstream processing.

The synchronizer latency is accounted for in the phase comparison. A word clock that is exactly in step with the counter therefore never causes a reload.

Top module: `wclk_phase_tracker`

## Requirements
- R1: While `rst` is high, and afterwards until the first start edge, `frame_cnt` is 0 and `locked`, `frame_strobe` and `resync` are 0.
- R2: When the first word-clock rise is sampled at clock edge k, then at edge k+2 `frame_cnt` becomes 2, and `locked` and `resync` become 1.
- R3: Once locked, `frame_cnt` advances by one every clock and wraps from `FRAME_LEN`-1 to 0, except in a realignment cycle.
- R4: `frame_strobe` is 1 exactly in the cycles where `locked` is 1 and `frame_cnt` is 0.
- R5: The phase error of a start edge sampled at edge k is the value `frame_cnt` takes at edge k, read as a signed number in [-`FRAME_LEN`/2, `FRAME_LEN`/2).
- R6: When `wide_mode` is 1, a start edge whose error e satisfies |e| <= 3*`FRAME_LEN`/8 (96 by default) causes no realignment. A larger error causes one.
- R7: When `wide_mode` is 0, a start edge with |e| <= 1 causes no realignment. Any larger error causes one.
- R8: A realignment loads `frame_cnt` with 2 at edge k+2 and raises `resync` for exactly that one cycle. The load takes precedence over the natural wrap, so no strobe appears for the skipped zero.
- R9: With no further start edges, the counter keeps running and `locked` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wclk_in | input | 1 | Asynchronous word clock; its rising edge marks a frame start |
| wide_mode | input | 1 | 1 selects the 3/8-frame tolerance, 0 selects the one-clock tolerance |
| frame_cnt | output | $clog2(FRAME_LEN) (8) | Frame phase counter |
| frame_strobe | output | 1 | High in the cycle where the counter is at phase zero |
| locked | output | 1 | High once the first start edge has aligned the counter |
| resync | output | 1 | One-cycle pulse on every alignment or realignment |

## Verification
The natural wrap of the counter and a realignment load can fall in the same cycle. This happens when a start edge arrives two clocks before a frame boundary. The bench provokes it in narrow mode by raising the word clock when the counter reads 253. The error is then -2, so the reload to 2 must win over the wrap to 0, and `frame_strobe` must stay low while `resync` goes high. The same offset in wide mode is used as the counter-case: the wrap must occur with its strobe, and no pulse must appear.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  // Signed distance of a counter value from an alignment point, folded
  // into the half-open range [-len/2, len/2).
  function automatic int wrap_err(input int value, input int align, input int len);
    int d;
    d = value - align;
    if (d >= len / 2)
      d = d - len;
    else if (d < -(len / 2))
      d = d + len;
    return d;
  endfunction

  function automatic int abs_int(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/wpt_sync.sv
module wpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/wpt_phase_cmp.sv
module wpt_phase_cmp
  import wpt_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int ALIGN     = 1,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             wide_mode,
  input  logic             locked,
  output logic             outside
);
  localparam int TOL_WIDE   = (3 * FRAME_LEN) / 8;
  localparam int TOL_NARROW = 1;

  int err_mag;

  always_comb begin
    err_mag = abs_int(wrap_err(int'(cnt), ALIGN, FRAME_LEN));
    if (!locked)
      outside = 1'b1;
    else if (wide_mode)
      outside = (err_mag > TOL_WIDE);
    else
      outside = (err_mag > TOL_NARROW);
  end
endmodule

// File: rtl/wpt_frame_ctr.sv
module wpt_frame_ctr #(
  parameter int FRAME_LEN = 256,
  parameter int LOAD_VAL  = 2,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_edge,
  input  logic             outside,
  output logic [CNT_W-1:0] cnt,
  output logic             locked,
  output logic             strobe,
  output logic             resync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOAD_VAL);

  logic             realign;
  logic             locked_nx;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    realign   = start_edge & outside;
    locked_nx = locked | start_edge;
    if (realign)
      cnt_nx = LOAD;
    else if (!locked)
      cnt_nx = '0;
    else if (cnt == LAST)
      cnt_nx = '0;
    else
      cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
      strobe <= 1'b0;
      resync <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      locked <= locked_nx;
      strobe <= locked_nx && (cnt_nx == '0);
      resync <= realign;
    end
  end
endmodule

// File: rtl/wclk_phase_tracker.sv
module wclk_phase_tracker #(
  parameter int FRAME_LEN   = 256,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk_in,
  input  logic             wide_mode,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             frame_strobe,
  output logic             locked,
  output logic             resync
);
  // Counter value seen during the detection cycle when in step, and the
  // value it must hold one clock later.
  localparam int ALIGN_VAL = SYNC_STAGES - 1;
  localparam int LOAD_VAL  = SYNC_STAGES;

  logic start_edge;
  logic outside;

  wpt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (wclk_in),
    .rise     (start_edge)
  );

  wpt_phase_cmp #(.FRAME_LEN(FRAME_LEN), .ALIGN(ALIGN_VAL), .CNT_W(CNT_W)) cmp_i (
    .cnt       (frame_cnt),
    .wide_mode (wide_mode),
    .locked    (locked),
    .outside   (outside)
  );

  wpt_frame_ctr #(.FRAME_LEN(FRAME_LEN), .LOAD_VAL(LOAD_VAL), .CNT_W(CNT_W)) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .start_edge (start_edge),
    .outside    (outside),
    .cnt        (frame_cnt),
    .locked     (locked),
    .strobe     (frame_strobe),
    .resync     (resync)
  );
endmodule

// File: rtl/wclk_phase_tracker_chk.sv
module wclk_phase_tracker_chk #(
  parameter int FRAME_LEN   = 256,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(FRAME_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] frame_cnt,
  input logic             frame_strobe,
  input logic             locked,
  input logic             resync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  a_r1_unlocked_idle: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (frame_cnt == '0) && !frame_strobe && !resync);

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (locked && !resync) |->
      (frame_cnt == (($past(frame_cnt) == LAST) ? '0 : $past(frame_cnt) + 1'b1)));

  a_r4_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> locked && (frame_cnt == '0));

  a_r8_resync_single: assert property (@(posedge clk) disable iff (rst)
    resync |=> !resync);

  a_r8_resync_load: assert property (@(posedge clk) disable iff (rst)
    resync |-> (frame_cnt == CNT_W'(SYNC_STAGES)) && locked);

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

bind wclk_phase_tracker wclk_phase_tracker_chk #(
  .FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .frame_cnt    (frame_cnt),
  .frame_strobe (frame_strobe),
  .locked       (locked),
  .resync       (resync)
);

// File: tb/wclk_phase_tracker_tb_top.sv
module wclk_phase_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 256;
  localparam int NVEC = 12;

  // Each vector: mode (1 = wide), requested phase error, realignment expected.
  localparam int VMODE [NVEC] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam int VOFF  [NVEC] = '{0, 96, 97, -96, -97, -2, -128, 1, -1, 2, -2, 0};
  localparam int VRSY  [NVEC] = '{0, 0, 1, 0, 1, 0, 1, 0, 0, 1, 1, 0};

  logic       clk = 1'b0;
  logic       rst;
  logic       wclk_in;
  logic       wide_mode;
  logic [7:0] frame_cnt;
  logic       frame_strobe;
  logic       locked;
  logic       resync;

  int checks = 0;
  int misses = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wclk_phase_tracker dut_i (
    .clk          (clk),
    .rst          (rst),
    .wclk_in      (wclk_in),
    .wide_mode    (wide_mode),
    .frame_cnt    (frame_cnt),
    .frame_strobe (frame_strobe),
    .locked       (locked),
    .resync       (resync)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin : main
    int c0;
    rst = 1'b1; wclk_in = 1'b0; wide_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cnt in reset", int'(frame_cnt), 0);
    chk("R1 locked in reset", int'(locked), 0);
    chk("R1 strobe in reset", int'(frame_strobe), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 cnt before first edge", int'(frame_cnt), 0);
    chk("R1 locked before first edge", int'(locked), 0);
    chk("R1 resync before first edge", int'(resync), 0);

    // First start edge (R2)
    wclk_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 cnt after first edge", int'(frame_cnt), 2);
    chk("R2 locked after first edge", int'(locked), 1);
    chk("R2 resync on first edge", int'(resync), 1);
    @(negedge clk);
    chk("R8 resync one cycle", int'(resync), 0);
    chk("R3 cnt advances", int'(frame_cnt), 3);
    wclk_in = 1'b0;

    // Wrap and strobe (R3, R4)
    while (frame_cnt != 8'd255) @(negedge clk);
    chk("R4 no strobe at 255", int'(frame_strobe), 0);
    @(negedge clk);
    chk("R3 wrap to zero", int'(frame_cnt), 0);
    chk("R4 strobe at zero", int'(frame_strobe), 1);
    @(negedge clk);
    chk("R4 strobe drops", int'(frame_strobe), 0);

    // Phase error vectors (R5, R6, R7, R8)
    for (int i = 0; i < NVEC; i++) begin
      int tgt;
      int exp_cnt;
      wide_mode = VMODE[i][0];
      repeat (3) @(negedge clk);
      tgt = (VOFF[i] - 1 + 2 * N) % N;
      while (int'(frame_cnt) != tgt) @(negedge clk);
      wclk_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_cnt = (VRSY[i] != 0) ? 2 : (VOFF[i] + 2 + 2 * N) % N;
      chk($sformatf("%s R5 resync vec %0d", (VMODE[i] != 0) ? "R6" : "R7", i),
          int'(resync), VRSY[i]);
      chk($sformatf("R8 cnt vec %0d", i), int'(frame_cnt), exp_cnt);
      chk($sformatf("R4 R8 strobe vec %0d", i), int'(frame_strobe), (exp_cnt == 0) ? 1 : 0);
      wclk_in = 1'b0;
    end

    // Free running with no edges (R9)
    repeat (600) @(negedge clk);
    chk("R9 locked holds", int'(locked), 1);
    c0 = int'(frame_cnt);
    @(negedge clk);
    chk("R9 cnt free runs", int'(frame_cnt), (c0 + 1) % N);
    chk("R9 no resync", int'(resync), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule